// File: doc/BRIEF.md
# Oversampled Serial Receiver with Per-Frame Flag FIFO

This block turns an asynchronous serial line into stored characters. A separate rate generator supplies a tick enable at sixteen times the bit rate. The receiver waits for the idle-high line to fall. It confirms the start bit at its centre, then decides each later bit by a three-sample majority vote. It assembles five to nine data bits, least significant first, and optionally checks a parity bit. Only the first stop bit is examined.

Each finished character is written into a short receive queue together with its own frame-error, parity-error and overflow flags. The head of the queue is always visible on the outputs. A host therefore takes the flags and the ninth bit first. It then pulses the data-read strobe, which retires the head entry so that the next character and its flags appear. Because the flags travel with their character, they always describe the byte currently shown.

Top module: `serial_rx_flagfifo`

## Requirements
- R1: A start is detected on a tick where the synchronised line is low after having been seen high on the previous tick. It is accepted only if the majority of the three mid-bit samples is low; otherwise the receiver returns to idle and stores nothing.
- R2: Each bit is decided by a majority of three samples taken at ticks 7, 8 and 9 of its 16-tick bit period. A disagreeing single sample does not change the result, while two disagreeing samples do.
- R3: Data bits arrive least significant first. `cfg_len` selects the length: values below 5 act as 5 and values above 9 act as 9. `rx_data` bits at or above the length read zero. `rx_bit8` carries the ninth bit and is zero for shorter frames.
- R4: When `par_en` is high, one parity bit follows the data bits. `par_odd`=0 selects even and `par_odd`=1 selects odd parity over all data bits. A mismatch sets `flag_parity` for that frame only. With `par_en` low there is no parity bit and the flag stays 0.
- R5: A first stop bit sampled low sets `flag_frame` for that frame, which is still stored. Bits after the first stop bit are not examined, and a new frame needs a fresh high-to-low transition.
- R6: Frames are queued in arrival order in a two-entry queue. `rx_ready` is high while at least one entry is held. The outputs show the oldest entry, and all data and flag outputs read zero when the queue is empty.
- R7: A one-cycle `rd_data` pulse removes the head entry, so the flags and data of the next entry appear on the following cycle. A pulse while the queue is empty has no effect.
- R8: A frame finishing while the queue is full, with no simultaneous read, is discarded. The newest stored entry then gets `flag_ovf` set, and older entries keep their contents.
- R9: After reset the queue is empty, every output is zero and the receiver is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Oversampling enable, 16 pulses per bit |
| rxd | input | 1 | Serial line, idle high |
| cfg_len | input | 4 | Data bits per frame (clamped to 5..9) |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| rd_data | input | 1 | Read strobe that removes the head entry |
| rx_data | output | 8 | Low data bits of the head entry |
| rx_bit8 | output | 1 | Ninth data bit of the head entry |
| flag_frame | output | 1 | Head entry had a low stop bit |
| flag_ovf | output | 1 | A later frame was lost after the head entry |
| flag_parity | output | 1 | Head entry failed its parity check |
| rx_ready | output | 1 | Queue holds at least one entry |

## Verification
The bench keeps the default queue depth of two and the default oversampling of sixteen ticks per bit. With a depth of two, a third unread frame overflows after only a few hundred ticks, so the drop-and-mark case is hit in directed tests and often again under random pacing of reads. Sixteen ticks give each bit a distinct mid-bit window. This lets the bench corrupt exactly one or exactly two of the three vote samples and check that the vote masks or follows the corruption.

// File: rtl/srx_pkg.sv
`timescale 1ns/1ps
package srx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_e;

    // One queued character with its own status.
    typedef struct packed {
        logic [7:0] data;
        logic       bit8;
        logic       ferr;
        logic       perr;
        logic       ovf;
    } rx_entry_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/srx_frame_rx.sv
`timescale 1ns/1ps
module srx_frame_rx
    import srx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick_en,
    input  logic      rxd,
    input  logic [3:0] cfg_len,
    input  logic      par_en,
    input  logic      par_odd,
    output logic      push_o,
    output rx_entry_t entry_o
);
    localparam int CW  = $clog2(OVS);
    localparam int MID = OVS / 2;
    localparam logic [CW-1:0] S_A   = CW'(MID - 1);
    localparam logic [CW-1:0] S_B   = CW'(MID);
    localparam logic [CW-1:0] S_V   = CW'(MID + 1);
    localparam logic [CW-1:0] S_END = CW'(OVS - 1);

    typedef struct packed {
        rx_state_e st;
        logic [CW-1:0] cnt;
        logic [3:0] bidx;
        logic [8:0] shreg;
        logic parbit;
        logic smp_a;
        logic smp_b;
        logic line_prev;
        logic sync1;
        logic sync2;
        logic push;
        rx_entry_t entry;
    } fr_state_t;

    fr_state_t q, n;
    logic [3:0] eff_len;
    logic line;
    logic vote;

    always_comb begin
        if (cfg_len < 4'd5)      eff_len = 4'd5;
        else if (cfg_len > 4'd9) eff_len = 4'd9;
        else                     eff_len = cfg_len;
    end

    always_comb begin
        n       = q;
        n.push  = 1'b0;
        n.sync1 = rxd;
        n.sync2 = q.sync1;
        line    = q.sync2;
        vote    = maj3(q.smp_a, q.smp_b, line);
        if (tick_en) begin
            n.line_prev = line;
            if (q.st == RX_IDLE) begin
                if (!line && q.line_prev) begin
                    n.st     = RX_START;
                    n.cnt    = CW'(1);
                    n.shreg  = '0;
                    n.parbit = 1'b0;
                end
            end else begin
                n.cnt = (q.cnt == S_END) ? '0 : q.cnt + CW'(1);
                if (q.cnt == S_A) n.smp_a = line;
                if (q.cnt == S_B) n.smp_b = line;
                if (q.cnt == S_V) begin
                    unique case (q.st)
                        RX_START: if (vote) n.st = RX_IDLE;
                        RX_DATA:  n.shreg[q.bidx] = vote;
                        RX_PAR:   n.parbit = vote;
                        RX_STOP: begin
                            n.push       = 1'b1;
                            n.entry.data = q.shreg[7:0];
                            n.entry.bit8 = q.shreg[8];
                            n.entry.ferr = ~vote;
                            n.entry.perr = par_en & ((^q.shreg) ^ q.parbit ^ par_odd);
                            n.entry.ovf  = 1'b0;
                            n.st         = RX_IDLE;
                        end
                        default: n.st = RX_IDLE;
                    endcase
                end
                if (q.cnt == S_END) begin
                    unique case (q.st)
                        RX_START: begin
                            n.st   = RX_DATA;
                            n.bidx = '0;
                        end
                        RX_DATA: begin
                            if (q.bidx == eff_len - 4'd1) n.st = par_en ? RX_PAR : RX_STOP;
                            else                          n.bidx = q.bidx + 4'd1;
                        end
                        RX_PAR:  n.st = RX_STOP;
                        default: n.st = q.st;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: RX_IDLE, cnt: '0, bidx: '0, shreg: '0, parbit: 1'b0,
                   smp_a: 1'b0, smp_b: 1'b0, line_prev: 1'b0, sync1: 1'b0,
                   sync2: 1'b0, push: 1'b0, entry: '0};
        end else begin
            q <= n;
        end
    end

    assign push_o  = q.push;
    assign entry_o = q.entry;

    // R5: a completed frame is reported for exactly one cycle
    a_r5_single_push: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |=> !push_o);

    // R1: without a tick the idle receiver stays idle
    a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == RX_IDLE && !tick_en) |=> (q.st == RX_IDLE));

    // R4: no parity error is reported while parity is off
    a_r4_no_perr: assert property (@(posedge clk) disable iff (!rst_n)
        (push_o && !$past(par_en)) |-> !entry_o.perr);

    // R8: a freshly assembled frame never carries the overflow mark
    a_r8_fresh_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |-> !entry_o.ovf);

endmodule

// File: rtl/srx_flag_fifo.sv
`timescale 1ns/1ps
module srx_flag_fifo
    import srx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push_i,
    input  rx_entry_t entry_i,
    input  logic      pop_i,
    output rx_entry_t head_o,
    output logic      ready_o
);
    localparam int AW   = $clog2(DEPTH);
    localparam int CNTW = $clog2(DEPTH + 1);
    localparam logic [CNTW-1:0] FULL = CNTW'(DEPTH);

    typedef struct packed {
        rx_entry_t [DEPTH-1:0] mem;
        logic [AW-1:0]   wptr;
        logic [AW-1:0]   rptr;
        logic [CNTW-1:0] count;
    } ff_state_t;

    ff_state_t q, n;
    logic do_pop, do_push, full;
    logic [AW-1:0] last_idx;

    always_comb begin
        n        = q;
        full     = (q.count == FULL);
        do_pop   = pop_i && (q.count != '0);
        do_push  = push_i && (!full || do_pop);
        last_idx = q.wptr - AW'(1);
        if (do_pop) n.rptr = q.rptr + AW'(1);
        if (do_push) begin
            n.mem[q.wptr] = entry_i;
            n.wptr        = q.wptr + AW'(1);
        end else if (push_i) begin
            n.mem[last_idx].ovf = 1'b1;
        end
        unique case ({do_push, do_pop})
            2'b10:   n.count = q.count + CNTW'(1);
            2'b01:   n.count = q.count - CNTW'(1);
            default: n.count = q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign ready_o = (q.count != '0);
    assign head_o  = ready_o ? q.mem[q.rptr] : '0;

    // R6: occupancy never exceeds the depth
    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.count <= FULL);

    // R7: a read of a non-empty queue with no arrival frees one entry
    a_r7_pop_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && ready_o && !push_i) |=> (q.count == $past(q.count) - CNTW'(1)));

    // R7: a read of an empty queue changes nothing
    a_r7_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !ready_o && !push_i) |=> !ready_o);

    // R8: an arrival at a full queue without a read leaves it full
    a_r8_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full && !pop_i) |=> (q.count == FULL) && head_o.data == $past(head_o.data));

endmodule

// File: rtl/serial_rx_flagfifo.sv
`timescale 1ns/1ps
module serial_rx_flagfifo
    import srx_pkg::*;
#(
    parameter int DEPTH = 2,
    parameter int OVS   = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       rxd,
    input  logic [3:0] cfg_len,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       rd_data,
    output logic [7:0] rx_data,
    output logic       rx_bit8,
    output logic       flag_frame,
    output logic       flag_ovf,
    output logic       flag_parity,
    output logic       rx_ready
);
    logic      push;
    rx_entry_t entry;
    rx_entry_t head;

    srx_frame_rx #(.OVS(OVS)) i_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .rxd     (rxd),
        .cfg_len (cfg_len),
        .par_en  (par_en),
        .par_odd (par_odd),
        .push_o  (push),
        .entry_o (entry)
    );

    srx_flag_fifo #(.DEPTH(DEPTH)) i_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .entry_i (entry),
        .pop_i   (rd_data),
        .head_o  (head),
        .ready_o (rx_ready)
    );

    assign rx_data     = head.data;
    assign rx_bit8     = head.bit8;
    assign flag_frame  = head.ferr;
    assign flag_ovf    = head.ovf;
    assign flag_parity = head.perr;

endmodule

// File: tb/test_serial_rx_flagfifo.sv
`timescale 1ns/1ps
module test_serial_rx_flagfifo;
    localparam int DEPTH = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       rxd = 1'b1;
    logic [3:0] cfg_len = 4'd8;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       rd_data = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit8, flag_frame, flag_ovf, flag_parity, rx_ready;

    serial_rx_flagfifo #(.DEPTH(DEPTH), .OVS(16)) i_serial_rx_flagfifo (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rxd(rxd),
        .cfg_len(cfg_len), .par_en(par_en), .par_odd(par_odd), .rd_data(rd_data),
        .rx_data(rx_data), .rx_bit8(rx_bit8), .flag_frame(flag_frame),
        .flag_ovf(flag_ovf), .flag_parity(flag_parity), .rx_ready(rx_ready)
    );

    always #10 clk = ~clk;

    logic [1:0] tcnt = 2'd0;
    always @(negedge clk) begin
        tcnt    <= tcnt + 2'd1;
        tick_en <= (tcnt == 2'd3);
    end

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic [7:0] d;
        logic b8, fe, pe, ov;
    } exp_t;
    exp_t mq[$];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int eff_len(input logic [3:0] c);
        if (c < 4'd5) return 5;
        if (c > 4'd9) return 9;
        return int'(c);
    endfunction

    task automatic wait_tick();
        @(posedge clk);
        while (!tick_en) @(posedge clk);
        @(negedge clk);
    endtask

    // g: 0 clean, 1 corrupt sample at tick 8, 2 corrupt ticks 8 and 9
    task automatic hold_bit(input logic v, input int g);
        for (int t = 0; t < 16; t++) begin
            rxd = ((g >= 1 && t == 8) || (g == 2 && t == 9)) ? ~v : v;
            wait_tick();
        end
    endtask

    task automatic send_frame(input logic [8:0] d, input bit bad_par, input bit bad_stop,
                              input int gbit, input int gn);
        int len;
        logic [8:0] dm, rcv;
        logic sp;
        exp_t e;
        len = eff_len(cfg_len);
        dm  = d & ((9'h1 << len) - 9'h1);
        rcv = dm;
        if (gn == 2 && gbit >= 0) rcv[gbit] = ~rcv[gbit];
        sp = (^dm) ^ par_odd ^ bad_par;
        hold_bit(1'b0, 0);
        for (int i = 0; i < len; i++) hold_bit(dm[i], (i == gbit) ? gn : 0);
        if (par_en) hold_bit(sp, 0);
        hold_bit(~bad_stop, 0);
        rxd = 1'b1;
        wait_tick();
        wait_tick();
        e.d  = rcv[7:0];
        e.b8 = rcv[8];
        e.fe = bad_stop;
        e.pe = par_en && ((^rcv) ^ sp ^ par_odd);
        e.ov = 1'b0;
        if (mq.size() < DEPTH) mq.push_back(e);
        else mq[mq.size() - 1].ov = 1'b1;
    endtask

    task automatic pop_check(input string req);
        exp_t e;
        if (mq.size() == 0) begin
            chk(req, {31'd0, rx_ready}, 32'd0, "ready on empty model");
        end else begin
            e = mq[0];
            chk(req, {19'd0, rx_ready, rx_data, rx_bit8, flag_frame, flag_parity, flag_ovf},
                {19'd0, 1'b1, e.d, e.b8, e.fe, e.pe, e.ov}, "head {ready,data,b8,fe,pe,ov}");
            rd_data = 1'b1;
            @(negedge clk);
            rd_data = 1'b0;
            void'(mq.pop_front());
        end
    endtask

    task automatic check_empty(input string req);
        chk(req, {19'd0, rx_ready, rx_data, rx_bit8, flag_frame, flag_parity, flag_ovf},
            32'd0, "empty outputs");
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL R6 watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int unsigned r;
        r = $urandom(32'd4711);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) wait_tick();
        check_empty("R9");

        // basic 8-bit frame, no parity
        cfg_len = 4'd8; par_en = 1'b0;
        send_frame(9'h0A5, 0, 0, -1, 0);
        pop_check("R6");
        check_empty("R7");

        // length handling
        cfg_len = 4'd5; send_frame(9'h1FF, 0, 0, -1, 0); pop_check("R3");
        cfg_len = 4'd9; send_frame(9'h155, 0, 0, -1, 0); pop_check("R3");
        cfg_len = 4'd7; send_frame(9'h0FF, 0, 0, -1, 0); pop_check("R3");
        cfg_len = 4'd2; send_frame(9'h1EA, 0, 0, -1, 0); pop_check("R3");
        cfg_len = 4'd14; send_frame(9'h1C3, 0, 0, -1, 0); pop_check("R3");

        // parity
        cfg_len = 4'd8; par_en = 1'b1;
        par_odd = 1'b0; send_frame(9'h037, 0, 0, -1, 0); pop_check("R4");
        par_odd = 1'b0; send_frame(9'h037, 1, 0, -1, 0); pop_check("R4");
        par_odd = 1'b1; send_frame(9'h0C1, 0, 0, -1, 0); pop_check("R4");
        par_odd = 1'b1; send_frame(9'h0C1, 1, 0, -1, 0); pop_check("R4");
        cfg_len = 4'd9; par_odd = 1'b0; send_frame(9'h100, 1, 0, -1, 0); pop_check("R4");
        par_en = 1'b0; cfg_len = 4'd8;

        // stop bit low, then a clean frame
        send_frame(9'h05A, 0, 1, -1, 0); pop_check("R5");
        send_frame(9'h0E7, 0, 0, -1, 0); pop_check("R5");
        check_empty("R5");

        // majority vote
        send_frame(9'h0F0, 0, 0, 2, 1); pop_check("R2");
        send_frame(9'h0F0, 0, 0, 3, 2); pop_check("R2");

        // false start: low only for four ticks
        rxd = 1'b0;
        repeat (4) wait_tick();
        rxd = 1'b1;
        repeat (20) wait_tick();
        check_empty("R1");
        send_frame(9'h081, 0, 0, -1, 0); pop_check("R1");

        // read strobe on empty queue
        rd_data = 1'b1; @(negedge clk); rd_data = 1'b0;
        check_empty("R7");
        send_frame(9'h03C, 0, 0, -1, 0);
        pop_check("R7");
        check_empty("R7");

        // ordering and overflow
        send_frame(9'h011, 0, 0, -1, 0);
        send_frame(9'h022, 1, 1, -1, 0);
        send_frame(9'h033, 0, 0, -1, 0);
        send_frame(9'h044, 0, 0, -1, 0);
        pop_check("R8");
        pop_check("R8");
        check_empty("R8");

        // random traffic
        for (int k = 0; k < 40; k++) begin
            cfg_len = 4'($urandom_range(0, 15));
            par_en  = 1'($urandom_range(0, 1));
            par_odd = 1'($urandom_range(0, 1));
            send_frame(9'($urandom_range(0, 511)), ($urandom_range(0, 5) == 0),
                       ($urandom_range(0, 7) == 0), -1, 0);
            for (int p = int'($urandom_range(0, 2)); p > 0; p--) pop_check("R6");
        end
        while (mq.size() > 0) pop_check("R6");
        check_empty("R6");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule